// File: doc/BRIEF.md
# Debug Halt Control and Status Register

This block is a single 32-bit register reached from an external debug port. Through it a debugger stops and restarts a small processor core, steps it one instruction at a time, keeps ordinary interrupts away from it while it is stepped or held, and breaks a load/store stall. Reading the same word gives live status from the core: halted, sleeping, locked up, core-register transfer ready, and a sticky flag that records a completed instruction.

The debug side presents a write strobe with data, or a read strobe. The read data is combinational and always shows the register's current value. A read strobe clears the sticky retire flag at the end of that cycle. A write is accepted only if its upper half carries the access key. After that, each control field has its own rule for when it may change. The core side drives halt-entry, retire, halted, sleeping, lockup and register-ready signals. It receives the halt, step, stall-break and interrupt-mask controls, and a masked copy of its ordinary interrupt request lines.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A write is accepted only when data bits 31:16 equal 16'hA05F. Any other write changes no bit of the register.
- R2: Control fields read back at these positions: debug-enable bit 0, halt bit 1, step bit 2, interrupt-mask bit 3, stall-break bit 5. Bit 4, bits 15:6, bits 23:20 and bits 31:25 always read 0.
- R3: Bit 24 (retire flag) becomes 1 in the cycle after a retire pulse. It keeps that value until a read strobe, and the read returns it before clearing it. A retire pulse in the same cycle as a read leaves the flag set.
- R4: Bit 19 reads 1 only while the lockup input is 1 and the core-halted input is 0.
- R5: Bit 18 mirrors the sleeping input, bit 17 mirrors the core-halted input and bit 16 mirrors the register-ready input.
- R6: A halt-entry pulse sets the halt control, even against an accepted write of 0 to it in the same cycle. Reset clears it. The halt output follows the halt control.
- R7: An accepted write can set stall-break only if debug-enable and halt were both 1 before the write. Setting it clears the retire flag, and while it is 1, retire pulses leave the flag at 0.
- R8: While debug-enable is 1 and the core is not halted, the step and interrupt-mask fields ignore writes. The step output is 0 whenever debug-enable is 0.
- R9: The interrupt-mask output is 1 when mask, debug-enable and either core-halted or step are all 1. While it is 1, every ordinary interrupt line is forwarded as 0. Otherwise each line passes unchanged.
- R10: With the core halted and debug-enable at 1, a write of step=1 with halt=0 releases the halt output with step high. The core's next retire and halt-entry pulses then give halt=1, halted=1 and retire=1 on readback.
- R11: After reset every control field and the retire flag are 0, and the halt, step, stall-break and interrupt-mask outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Debug write strobe |
| wrData | input | 32 | Write data; bits 31:16 carry the key |
| rdEn | input | 1 | Debug read strobe; clears the retire flag |
| rdData | output | 32 | Current register value |
| retireIn | input | 1 | Core completed an instruction |
| haltEntryIn | input | 1 | Core entered the halted state |
| coreHaltedIn | input | 1 | Core is halted |
| sleepIn | input | 1 | Core is waiting in sleep |
| lockupIn | input | 1 | Core lockup condition |
| regRdyIn | input | 1 | Core-register transfer ready |
| irqReqIn | input | NUM_IRQ | Ordinary interrupt requests |
| haltOut | output | 1 | Halt request to the core |
| stepOut | output | 1 | Single-step request to the core |
| stallBrkOut | output | 1 | Force a stalled load/store to complete |
| maskIntOut | output | 1 | Ordinary interrupts masked |
| irqFwdOut | output | NUM_IRQ | Interrupt requests after masking |

## Verification
The bench targets the corner cases where one field's rule depends on another field's old value. Stall-break is requested while halt is still clear, and step and mask are written while the core runs with debug enabled. A design that used the incoming write data instead of the stored state would set stall-break or take the step. The bench also sends a halt-entry pulse together with a write that clears halt, which catches a design that lets the write win. It sends a retire pulse together with a read, which catches a design that loses the sticky flag. A key that is off by any bit must leave the readback unchanged. A full single-step round trip checks that halt, halted and retire all reappear together.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [15:0] WR_KEY = 16'hA05F;

  localparam int B_DBGEN  = 0;
  localparam int B_HALT   = 1;
  localparam int B_STEP   = 2;
  localparam int B_MASK   = 3;
  localparam int B_STALL  = 5;
  localparam int B_REGRDY = 16;
  localparam int B_HALTED = 17;
  localparam int B_SLEEP  = 18;
  localparam int B_LOCKUP = 19;
  localparam int B_RETIRE = 24;

  typedef struct packed {
    logic wrAccept;    // key matched
    logic stepMaskOk;  // step/mask fields may be written
    logic stallOk;     // stall-break may be set
    logic readClr;     // read strobe clears sticky
  } ctlStrobe_t;
endpackage

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
(
  input  logic        wrEn,
  input  logic [15:0] wrKey,
  input  logic        rdEn,
  input  logic        debugEn,
  input  logic        haltCtl,
  input  logic        coreHaltedIn,
  output ctlStrobe_t  strb
);
  logic keyOk;
  logic runLocked;

  assign keyOk     = (wrKey == WR_KEY);
  assign runLocked = debugEn && !coreHaltedIn;

  always_comb begin
    strb            = '0;
    strb.wrAccept   = wrEn && keyOk;
    strb.stepMaskOk = wrEn && keyOk && !runLocked;
    strb.stallOk    = wrEn && keyOk && debugEn && haltCtl;
    strb.readClr    = rdEn;
  end
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [15:0]        wrLow,
  input  logic               retireIn,
  input  logic               haltEntryIn,
  input  logic               coreHaltedIn,
  input  logic               sleepIn,
  input  logic               lockupIn,
  input  logic               regRdyIn,
  input  logic [NUM_IRQ-1:0] irqReqIn,
  output logic [31:0]        rdData,
  output logic               debugEn,
  output logic               haltCtl,
  output logic               haltOut,
  output logic               stepOut,
  output logic               stallBrkOut,
  output logic               maskIntOut,
  output logic [NUM_IRQ-1:0] irqFwdOut
);
  logic stepCtl, maskCtl, stallBrk, retireSticky;
  logic stallSet;

  assign stallSet = strb.stallOk && wrLow[B_STALL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      debugEn  <= 1'b0;
      haltCtl  <= 1'b0;
      stallBrk <= 1'b0;
    end else if (strb.wrAccept) begin
      debugEn  <= wrLow[B_DBGEN];
      haltCtl  <= wrLow[B_HALT] || haltEntryIn;
      stallBrk <= stallSet;
    end else if (haltEntryIn) begin
      haltCtl  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCtl <= 1'b0;
      maskCtl <= 1'b0;
    end else if (strb.stepMaskOk) begin
      stepCtl <= wrLow[B_STEP];
      maskCtl <= wrLow[B_MASK];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       retireSticky <= 1'b0;
    else if (stallSet)               retireSticky <= 1'b0;
    else if (retireIn && !stallBrk)  retireSticky <= 1'b1;
    else if (strb.readClr)           retireSticky <= 1'b0;
  end

  always_comb begin
    rdData           = '0;
    rdData[B_DBGEN]  = debugEn;
    rdData[B_HALT]   = haltCtl;
    rdData[B_STEP]   = stepCtl;
    rdData[B_MASK]   = maskCtl;
    rdData[B_STALL]  = stallBrk;
    rdData[B_REGRDY] = regRdyIn;
    rdData[B_HALTED] = coreHaltedIn;
    rdData[B_SLEEP]  = sleepIn;
    rdData[B_LOCKUP] = lockupIn && !coreHaltedIn;
    rdData[B_RETIRE] = retireSticky;
  end

  assign haltOut     = haltCtl;
  assign stepOut     = stepCtl && debugEn;
  assign stallBrkOut = stallBrk;
  assign maskIntOut  = maskCtl && debugEn && (coreHaltedIn || stepCtl);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irqGate
    assign irqFwdOut[i] = irqReqIn[i] && !maskIntOut;
  end

  AST_HALT_ENTRY_SET: assert property (@(posedge clk) disable iff (!rstN)
    haltEntryIn |=> haltCtl); // R6
  AST_STALL_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallBrk) |-> $past(debugEn && haltCtl)); // R7
  AST_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (debugEn && !coreHaltedIn) |=> ($stable(stepCtl) && $stable(maskCtl))); // R8
  AST_RETIRE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (retireIn && !stallBrk && !stallSet) |=> retireSticky); // R3
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  input  logic               rdEn,
  output logic [31:0]        rdData,
  input  logic               retireIn,
  input  logic               haltEntryIn,
  input  logic               coreHaltedIn,
  input  logic               sleepIn,
  input  logic               lockupIn,
  input  logic               regRdyIn,
  input  logic [NUM_IRQ-1:0] irqReqIn,
  output logic               haltOut,
  output logic               stepOut,
  output logic               stallBrkOut,
  output logic               maskIntOut,
  output logic [NUM_IRQ-1:0] irqFwdOut
);
  ctlStrobe_t strb;
  logic debugEn, haltCtl;

  dbg_ctrl u_ctrl (
    .wrEn(wrEn), .wrKey(wrData[31:16]), .rdEn(rdEn),
    .debugEn(debugEn), .haltCtl(haltCtl), .coreHaltedIn(coreHaltedIn),
    .strb(strb)
  );

  dbg_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrLow(wrData[15:0]),
    .retireIn(retireIn), .haltEntryIn(haltEntryIn), .coreHaltedIn(coreHaltedIn),
    .sleepIn(sleepIn), .lockupIn(lockupIn), .regRdyIn(regRdyIn),
    .irqReqIn(irqReqIn), .rdData(rdData), .debugEn(debugEn), .haltCtl(haltCtl),
    .haltOut(haltOut), .stepOut(stepOut), .stallBrkOut(stallBrkOut),
    .maskIntOut(maskIntOut), .irqFwdOut(irqFwdOut)
  );

  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[31:16] != WR_KEY && !haltEntryIn) |=> $stable(rdData[5:0])); // R1
  AST_LOCKUP_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    coreHaltedIn |-> !rdData[B_LOCKUP]); // R4
endmodule

// File: tb/dbg_halt_ctl_tb.sv
`timescale 1ns/1ps
module dbg_halt_ctl_tb;
  localparam int NI = 8;
  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0;
  logic [31:0] wrData = '0, rdData;
  logic retireIn = 0, haltEntryIn = 0, coreHaltedIn = 0, sleepIn = 0, lockupIn = 0, regRdyIn = 1;
  logic [NI-1:0] irqReqIn = 8'hA5, irqFwdOut;
  logic haltOut, stepOut, stallBrkOut, maskIntOut;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  dbg_halt_ctl #(.NUM_IRQ(NI)) u_dut (.*);

  // monitor: pops expected readback when a read is presented
  always @(negedge clk) begin
    if (rstN && rdEn && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s readback actual=%h expected=%h", t, rdData, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step1();
    @(posedge clk); #1;
  endtask

  task automatic doWrite(input logic [31:0] d);
    step1(); wrEn = 1; wrData = d;
    step1(); wrEn = 0; wrData = '0;
  endtask

  task automatic doRead(input logic [31:0] e, input string t);
    step1(); rdEn = 1; expQ.push_back(e); tagQ.push_back(t);
    step1(); rdEn = 0;
  endtask

  task automatic pulseRetire();
    step1(); retireIn = 1;
    step1(); retireIn = 0;
  endtask

  task automatic chk(input logic [31:0] a, input logic [31:0] e, input string t);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  initial begin
    repeat (3) step1();
    rstN = 1;
    step1();
    chk({31'b0, haltOut}, 0, "R11 halt out");
    chk({31'b0, stepOut | maskIntOut | stallBrkOut}, 0, "R11 outs");
    doRead(32'h0001_0000, "R11 reset value");
    doWrite(32'h1234_0003);
    doRead(32'h0001_0000, "R1 bad key");
    doWrite(32'hA05E_0003);
    doRead(32'h0001_0000, "R1 key off by one");
    doWrite(32'hA05F_FFF3); // reserved bits and stall-break with debug-enable off
    doRead(32'h0001_0003, "R2 R7 layout");
    chk({31'b0, haltOut}, 1, "R6 halt out");
    coreHaltedIn = 1;
    doRead(32'h0003_0003, "R5 halted bit");
    pulseRetire();
    doWrite(32'hA05F_002B);
    doRead(32'h0003_002B, "R7 stall set clears retire");
    chk({31'b0, maskIntOut}, 1, "R9 mask out");
    chk({24'b0, irqFwdOut}, 0, "R9 irq blocked");
    chk({31'b0, stallBrkOut}, 1, "R7 stall out");
    pulseRetire();
    doRead(32'h0003_002B, "R7 retire held at 0");
    doWrite(32'hA05F_0003);
    doRead(32'h0003_0003, "R7 stall clear");
    chk({24'b0, irqFwdOut}, 32'hA5, "R9 irq pass");
    coreHaltedIn = 0;
    doWrite(32'hA05F_000F);
    doRead(32'h0001_0003, "R8 running write ignored");
    lockupIn = 1;
    doRead(32'h0009_0003, "R4 lockup running");
    coreHaltedIn = 1;
    doRead(32'h0003_0003, "R4 lockup halted");
    lockupIn = 0; sleepIn = 1;
    doRead(32'h0007_0003, "R5 sleep");
    sleepIn = 0; regRdyIn = 0;
    doRead(32'h0002_0003, "R5 regready");
    regRdyIn = 1;
    doWrite(32'hA05F_0006);
    doRead(32'h0003_0006, "R8 step stored");
    chk({31'b0, stepOut}, 0, "R8 step gated by debug enable");
    step1(); wrEn = 1; wrData = 32'hA05F_0000; haltEntryIn = 1;
    step1(); wrEn = 0; wrData = '0; haltEntryIn = 0;
    doRead(32'h0003_0002, "R6 entry beats write");
    pulseRetire();
    doRead(32'h0103_0002, "R3 sticky set");
    doRead(32'h0003_0002, "R3 cleared by read");
    pulseRetire();
    step1(); rdEn = 1; retireIn = 1; expQ.push_back(32'h0103_0002); tagQ.push_back("R3 read with retire");
    step1(); rdEn = 0; retireIn = 0;
    doRead(32'h0103_0002, "R3 set wins");
    doRead(32'h0003_0002, "R3 clear after");
    doWrite(32'hA05F_0003);
    doWrite(32'hA05F_0005);
    chk({31'b0, haltOut}, 0, "R10 released");
    chk({31'b0, stepOut}, 1, "R10 step high");
    step1(); coreHaltedIn = 0;
    step1(); retireIn = 1; haltEntryIn = 1;
    step1(); retireIn = 0; haltEntryIn = 0; coreHaltedIn = 1;
    doRead(32'h0103_0007, "R10 rehalt");
    chk({31'b0, haltOut}, 1, "R10 halt out");
    coreHaltedIn = 0;
    step1(); rstN = 0;
    step1(); step1(); rstN = 1;
    doRead(32'h0001_0000, "R11 reset again");
    chk({31'b0, haltOut}, 0, "R6 reset clears halt");
    repeat (2) step1();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule